// File: doc/BRIEF.md
# Down-Counting Reload Timer with Waveform Output

This block is a 16-bit timer that counts down on a single-cycle count tick supplied from outside. Software reaches it through a small register port with three locations: an 8-bit control/status byte, a reload value and a read-only copy of the live counter. Once the timer has been armed with the run-enable bit, writing the start bit copies the reload value into the counter and counting begins. When the counter passes below zero, the timer either halts (single-pass mode) or copies the reload value in again and carries on (auto-reload mode). Each pass below zero sets a sticky flag. The flag can drive an interrupt request.

The timer drives one output pin. In single-pass mode the pin holds one level for as long as the counter runs. In auto-reload mode it inverts on every pass below zero, which gives a square wave. A polarity bit picks the active level in single-pass mode and the starting level in auto-reload mode. An output-enable bit chooses between the timer waveform and a general-purpose level supplied from outside.

Top module: `reload_timer`

## Requirements
- R1: After reset the control byte reads 0x00, the counter reads 0, the interrupt request is low and the pin follows the general-purpose level.
- R2: The control byte at address 0 holds: bit1 run enable, bit2 underflow flag, bit3 interrupt enable, bit4 auto-reload select, bit5 polarity, bit6 output enable. Bit0 (start) and bit7 always read 0. Address 1 holds the reload value and address 2 returns the counter.
- R3: A control write with bit0=1 and bit1=1 loads the counter from the reload value held before that write and starts counting. A start request written with bit1=0 leaves the counter unchanged and does not start the timer.
- R4: While the timer runs, each cycle with the count tick high decrements the counter by one. Cycles without a tick leave the counter unchanged.
- R5: A tick while the running counter is 0 is an underflow and sets bit2. A control write with bit2=0 clears the flag and a write with bit2=1 leaves it as it is. An underflow in the same cycle as a clearing write leaves the flag set.
- R6: In auto-reload mode (bit4=1) an underflow loads the counter from the reload value, and counting continues.
- R7: In single-pass mode (bit4=0) an underflow leaves the counter at 0xFFFF and stops the timer. Later ticks leave the counter unchanged.
- R8: In single-pass mode the timer output is the inverse of bit5 while the timer runs and equals bit5 while it is idle.
- R9: In auto-reload mode the timer output takes the value of bit5 on start and inverts on every underflow.
- R10: The pin carries the timer output when bit6=1 and the general-purpose level when bit6=0.
- R11: The interrupt request is high exactly when both bit2 and bit3 are 1.
- R12: Writing bit1=0 stops the timer at that write. The counter then ignores ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 control, 1 reload, 2 counter) |
| regWrData | input | 16 | Write data (the control byte uses bits 7:0) |
| regRdData | output | 16 | Read data for regAddr, combinational |
| countTick | input | 1 | One-cycle count-enable tick |
| gpioLevel | input | 1 | Level driven on the pin when the timer output is disabled |
| pinOut | output | 1 | Pin level |
| irqOut | output | 1 | Underflow interrupt request |

## Verification
Directed sequences cover each mode separately. A single-pass run with each polarity distinguishes the level-pulse output from the toggle output. An auto-reload run with a reload value of 1 shows the reload-and-continue path and the inversion on every underflow. Dedicated cases cover a start written while disarmed, a flag clear that lands in the same cycle as an underflow, and a disarm while the counter is running. These cases tell apart priority mistakes that random traffic rarely hits. Seeded random traffic then mixes control writes, reload writes of small values (so underflows are frequent), irregular ticks and a changing general-purpose level. That traffic exposes ordering faults between writes, restarts and underflows that land in the same cycle.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;

  localparam int CTRL_W    = 8;
  localparam int BIT_START = 0;
  localparam int BIT_RUN   = 1;
  localparam int BIT_UF    = 2;
  localparam int BIT_IE    = 3;
  localparam int BIT_AUTO  = 4;
  localparam int BIT_POL   = 5;
  localparam int BIT_OE    = 6;

  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_RELOAD = 1;
  localparam int ADDR_COUNT  = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic dec;
  } dpStrobe_t;

endpackage

// File: rtl/rt_datapath.sv
module rt_datapath
  import reload_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic             reloadWr,
  input  logic [CNT_W-1:0] reloadIn,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reloadVal,
  output logic             cntZero
);

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] reloadQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadQ <= '0;
    end else if (reloadWr) begin
      reloadQ <= reloadIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (stb.load) begin
      countQ <= reloadQ;
    end else if (stb.dec) begin
      countQ <= countQ - 1'b1;
    end
  end

  assign count     = countQ;
  assign reloadVal = reloadQ;
  assign cntZero   = (countQ == '0);

  // R3: a load takes the reload value held before the edge
  a_r3_load_value: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.load) |-> countQ == $past(reloadQ));

  // R4: a decrement lowers the count by exactly one
  a_r4_decrement: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.dec) && !$past(stb.load) |-> (countQ + 1'b1) == $past(countQ));

endmodule

// File: rtl/rt_control.sv
module rt_control
  import reload_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrCtrl,
  input  logic [CTRL_W-1:0] wrByte,
  input  logic              countTick,
  input  logic              cntZero,
  output dpStrobe_t         stb,
  output logic [CTRL_W-1:0] ctrlByte,
  output logic              timerOut,
  output logic              irqOut
);

  logic runEnQ, ufQ, ieQ, autoQ, polQ, oeQ;
  logic runQ, toggleQ;
  logic startReq, underflow, autoReload;

  assign startReq   = wrCtrl && wrByte[BIT_START] && wrByte[BIT_RUN];
  assign underflow  = countTick && runQ && cntZero && !startReq;
  assign autoReload = underflow && autoQ;

  always_comb begin
    stb      = '0;
    stb.load = startReq || autoReload;
    stb.dec  = countTick && runQ && !startReq && !autoReload;
  end

  // software-visible control bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEnQ <= 1'b0;
      ieQ    <= 1'b0;
      autoQ  <= 1'b0;
      polQ   <= 1'b0;
      oeQ    <= 1'b0;
    end else if (wrCtrl) begin
      runEnQ <= wrByte[BIT_RUN];
      ieQ    <= wrByte[BIT_IE];
      autoQ  <= wrByte[BIT_AUTO];
      polQ   <= wrByte[BIT_POL];
      oeQ    <= wrByte[BIT_OE];
    end
  end

  // sticky flag: a set beats a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ufQ <= 1'b0;
    end else if (underflow) begin
      ufQ <= 1'b1;
    end else if (wrCtrl && !wrByte[BIT_UF]) begin
      ufQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ <= 1'b0;
    end else if (startReq) begin
      runQ <= 1'b1;
    end else if (wrCtrl && !wrByte[BIT_RUN]) begin
      runQ <= 1'b0;
    end else if (underflow && !autoQ) begin
      runQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toggleQ <= 1'b0;
    end else if (startReq) begin
      toggleQ <= wrByte[BIT_POL];
    end else if (autoReload) begin
      toggleQ <= !toggleQ;
    end
  end

  assign ctrlByte = {1'b0, oeQ, polQ, autoQ, ieQ, ufQ, runEnQ, 1'b0};
  assign timerOut = autoQ ? toggleQ : (runQ ? !polQ : polQ);
  assign irqOut   = ufQ && ieQ;

  // R12: a disarmed timer never counts
  a_r12_halted: assert property (@(posedge clk) disable iff (!rstN)
    !runEnQ |-> !runQ);

  // R5: the flag only rises after a tick on a zero count
  a_r5_flag_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ufQ) |-> $past(countTick && runQ && cntZero));

  // R7: single-pass underflow stops the timer
  a_r7_single_stop: assert property (@(posedge clk) disable iff (!rstN)
    $past(countTick && runQ && cntZero && !autoQ && !startReq) |-> !runQ);

  // R9: auto-reload underflow inverts the waveform
  a_r9_toggle: assert property (@(posedge clk) disable iff (!rstN)
    $past(countTick && runQ && cntZero && autoQ && !startReq) |-> toggleQ != $past(toggleQ));

endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import reload_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              countTick,
  input  logic              gpioLevel,
  output logic              pinOut,
  output logic              irqOut
);

  dpStrobe_t         stb;
  logic [CTRL_W-1:0] ctrlByte;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  reloadVal;
  logic              cntZero;
  logic              timerOut;
  logic              wrCtrl;
  logic              wrReload;

  assign wrCtrl   = regWrEn && (int'(regAddr) == ADDR_CTRL);
  assign wrReload = regWrEn && (int'(regAddr) == ADDR_RELOAD);

  rt_control uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrCtrl    (wrCtrl),
    .wrByte    (regWrData[CTRL_W-1:0]),
    .countTick (countTick),
    .cntZero   (cntZero),
    .stb       (stb),
    .ctrlByte  (ctrlByte),
    .timerOut  (timerOut),
    .irqOut    (irqOut)
  );

  rt_datapath #(.CNT_W(CNT_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reloadWr  (wrReload),
    .reloadIn  (regWrData[CNT_W-1:0]),
    .count     (count),
    .reloadVal (reloadVal),
    .cntZero   (cntZero)
  );

  always_comb begin
    regRdData = '0;
    case (int'(regAddr))
      ADDR_CTRL:   regRdData[CTRL_W-1:0] = ctrlByte;
      ADDR_RELOAD: regRdData[CNT_W-1:0]  = reloadVal;
      ADDR_COUNT:  regRdData[CNT_W-1:0]  = count;
      default:     regRdData = '0;
    endcase
  end

  assign pinOut = ctrlByte[BIT_OE] ? timerOut : gpioLevel;

endmodule

// File: tb/reload_timer_test.sv
`timescale 1ns/1ps
module reload_timer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWrData = 16'd0;
  logic [15:0] regRdData;
  logic        countTick = 1'b0;
  logic        gpioLevel = 1'b0;
  logic        pinOut;
  logic        irqOut;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // reference model state
  logic mEn = 0, mUf = 0, mIe = 0, mAuto = 0, mPol = 0, mOe = 0;
  logic mRun = 0, mTog = 0;
  logic [15:0] mCount = 0, mReload = 0;

  always #2.5 clk = ~clk;

  reload_timer uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .countTick(countTick),
    .gpioLevel(gpioLevel), .pinOut(pinOut), .irqOut(irqOut)
  );

  function automatic logic [15:0] expCtrl();
    return {8'h00, 1'b0, mOe, mPol, mAuto, mIe, mUf, mEn, 1'b0};
  endfunction

  function automatic logic expPin();
    logic t;
    t = mAuto ? mTog : (mRun ? !mPol : mPol);
    return mOe ? t : gpioLevel;
  endfunction

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic readReg(logic [1:0] a, output logic [15:0] v);
    regAddr = a;
    #0.4;
    v = regRdData;
  endtask

  task automatic modelEdge(logic wr, logic [1:0] a, logic [15:0] d, logic tk);
    logic wc, st, uev;
    logic [15:0] nCount;
    wc = wr && (a == 2'd0);
    st = wc && d[0] && d[1];
    uev = tk && mRun && !st && (mCount == 16'd0);
    nCount = mCount;
    if (st) nCount = mReload;
    else if (tk && mRun) nCount = (mCount == 16'd0) ? (mAuto ? mReload : 16'hFFFF) : mCount - 16'd1;
    if (st) mTog = d[5];
    else if (uev && mAuto) mTog = !mTog;
    if (st) mRun = 1'b1;
    else if (wc && !d[1]) mRun = 1'b0;
    else if (uev && !mAuto) mRun = 1'b0;
    if (uev) mUf = 1'b1;
    else if (wc && !d[2]) mUf = 1'b0;
    if (wc) begin
      mEn = d[1]; mIe = d[3]; mAuto = d[4]; mPol = d[5]; mOe = d[6];
    end
    if (wr && a == 2'd1) mReload = d;
    mCount = nCount;
  endtask

  task automatic compareAll();
    logic [15:0] v;
    readReg(2'd0, v); chk("R2 control byte", v, expCtrl());
    readReg(2'd2, v); chk("R4 counter", v, mCount);
    chk("R10 pin", {15'd0, pinOut}, {15'd0, expPin()});
    chk("R11 irq", {15'd0, irqOut}, {15'd0, mUf && mIe});
  endtask

  task automatic step(logic wr, logic [1:0] a, logic [15:0] d, logic tk, logic gp);
    regWrEn = wr; regAddr = a; regWrData = d; countTick = tk; gpioLevel = gp;
    @(posedge clk);
    modelEdge(wr, a, d, tk);
    @(negedge clk);
    regWrEn = 1'b0; countTick = 1'b0;
    compareAll();
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish();
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'h5EED));
    gpioLevel = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    readReg(2'd0, v); chk("R1 control", v, 16'h0000);
    readReg(2'd2, v); chk("R1 counter", v, 16'h0000);
    chk("R1 irq", {15'd0, irqOut}, 16'd0);
    chk("R1 pin", {15'd0, pinOut}, 16'd1);

    // R3 start ignored while disarmed
    step(1, 2'd1, 16'd5, 0, 1);
    step(1, 2'd0, 16'h0001, 0, 1);
    readReg(2'd2, v); chk("R3 ignored start", v, 16'd0);
    readReg(2'd0, v); chk("R3 not armed", v, 16'h0000);

    // R3 start, R2 start bit reads 0, R10 pin disabled
    step(1, 2'd0, 16'h0003, 0, 0);
    readReg(2'd2, v); chk("R3 load", v, 16'd5);
    readReg(2'd0, v); chk("R2 start reads 0", v, 16'h0002);
    chk("R10 gpio", {15'd0, pinOut}, 16'd0);

    // R8 single pass, polarity 0
    step(1, 2'd0, 16'h0043, 0, 0);
    chk("R8 high while running", {15'd0, pinOut}, 16'd1);
    for (int i = 0; i < 5; i++) step(0, 2'd0, 16'd0, 1, 0);
    readReg(2'd2, v); chk("R4 reached zero", v, 16'd0);
    step(0, 2'd0, 16'd0, 0, 0);
    readReg(2'd2, v); chk("R4 no tick hold", v, 16'd0);
    step(0, 2'd0, 16'd0, 1, 0);
    readReg(2'd2, v); chk("R7 wraps to FFFF", v, 16'hFFFF);
    readReg(2'd0, v); chk("R5 flag set", v, 16'h0046);
    chk("R8 idle low", {15'd0, pinOut}, 16'd0);
    step(0, 2'd0, 16'd0, 1, 0);
    readReg(2'd2, v); chk("R7 stays stopped", v, 16'hFFFF);

    // R11 / R5 flag write semantics
    step(1, 2'd0, 16'h004E, 0, 0);
    chk("R11 irq high", {15'd0, irqOut}, 16'd1);
    step(1, 2'd0, 16'h004A, 0, 0);
    readReg(2'd0, v); chk("R5 flag cleared", v, 16'h004A);
    chk("R11 irq low", {15'd0, irqOut}, 16'd0);

    // R8 polarity 1
    step(1, 2'd0, 16'h0063, 0, 0);
    chk("R8 low while running", {15'd0, pinOut}, 16'd0);

    // R6 / R9 auto-reload
    step(1, 2'd1, 16'd1, 0, 0);
    step(1, 2'd0, 16'h0053, 0, 0);
    chk("R9 start low", {15'd0, pinOut}, 16'd0);
    step(0, 2'd0, 16'd0, 1, 0);
    step(0, 2'd0, 16'd0, 1, 0);
    readReg(2'd2, v); chk("R6 reloaded", v, 16'd1);
    chk("R9 toggled high", {15'd0, pinOut}, 16'd1);
    step(0, 2'd0, 16'd0, 1, 0);
    step(1, 2'd0, 16'h0052, 1, 0);
    readReg(2'd0, v); chk("R5 set beats clear", v, 16'h0056);
    chk("R9 toggled low", {15'd0, pinOut}, 16'd0);

    // R12 disarm stops counting
    step(1, 2'd0, 16'h0050, 0, 0);
    step(0, 2'd0, 16'd0, 1, 0);
    readReg(2'd2, v); chk("R12 halted", v, 16'd1);

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [15:0] d;
      r = $urandom % 10;
      d = {8'h00, 8'($urandom)};
      if (($urandom % 5) != 0) d[1] = 1'b1;
      if (r < 2) step(1, 2'd0, d, 1'($urandom), 1'($urandom));
      else if (r == 2) step(1, 2'd1, 16'($urandom % 6), 1'($urandom), 1'($urandom));
      else step(0, 2'd0, 16'd0, 1'($urandom), 1'($urandom));
    end
    finish();
  end

endmodule